// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Engine

This block is a bus master that copies a block of words between one peripheral and system memory so that the processor does not handle each word itself. Software loads a peripheral address, a memory start address and a word count, then issues a start command that also selects the direction. From that point the engine competes for the shared bus one transaction at a time. It asks for the bus, performs a single access once the grant arrives, and releases the bus before the next access. The processor is only held off while its own bus access would collide. It never takes an exception for an individual word.

The peripheral and memory share one bus, so every word needs two accesses. The first reads the source into an internal one-word holding register. The second writes that word to the destination. The memory address advances by one per word and the peripheral address stays fixed. When the last word has been written, the engine raises an interrupt. The interrupt stays high until software clears it. A start with a word count of zero completes at once, with no bus traffic.

Top module: `cs_dma_top`

## Requirements
- R1: After reset, `busy`, `irq`, `bus_req` and `bus_valid` are all low.
- R2: A programming write selects its target with `prog_sel`: 0 loads the peripheral address, 1 loads the memory start address, 2 loads the word count, 3 is the command. In the command, bit 0 is the direction (0 = peripheral to memory, 1 = memory to peripheral), bit 1 starts a block and bit 2 clears the done flag.
- R3: Every word uses exactly two bus transactions. The first is a read of the source and the second is a write to the destination, carrying the word from the first read. `bus_io` is high for a peripheral access and low for a memory access, and `bus_we` is high for a write.
- R4: `bus_valid`, together with the address, data and control it qualifies, is asserted only in a cycle where `bus_req` and `bus_grant` are both high. `bus_req` is low in the cycle after every transaction.
- R5: Word i of a block uses memory address start+i and always the programmed peripheral address. A block contains exactly the programmed number of words.
- R6: `busy` falls and `irq` rises on the clock edge that completes the final write transaction.
- R7: `irq` stays high until a command with the clear bit or the start bit is accepted.
- R8: A start with a word count of zero raises `irq` on the next edge, never raises `busy`, and causes no bus transaction.
- R9: Programming writes, including commands, that arrive while `busy` is high are ignored.
- R10: `busy` is high from the edge that accepts a nonzero start until the edge in R6, and can be observed in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_wr | input | 1 | Programming write strobe |
| prog_sel | input | 2 | Programming target select |
| prog_wdata | input | DW | Programming write data |
| busy | output | 1 | Block transfer in progress |
| irq | output | 1 | Block-complete interrupt (done flag) |
| bus_req | output | 1 | Bus ownership request |
| bus_grant | input | 1 | Bus ownership grant |
| bus_valid | output | 1 | Transaction performed this cycle |
| bus_we | output | 1 | Transaction is a write |
| bus_io | output | 1 | Transaction targets the peripheral |
| bus_addr | output | AW | Transaction address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data returned in the same cycle |

## Verification
Completion of a block and acceptance of a programming write can fall in the same cycle. The edge that retires the last write also lowers `busy`, so a command arriving in that cycle must still be refused. The bench holds a start command on the programming port for the whole length of a block and keeps it there one cycle past the drop of `busy`. The reference model expects the completion-cycle command to be ignored and the following one to launch a second block with unchanged settings. Every transaction, and `busy` and `irq` in every cycle, are compared against that expectation.

// File: rtl/cs_dma_pkg.sv
package cs_dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC,
        ST_HOLD,
        ST_DST,
        ST_REST
    } seq_st_e;

    localparam logic [1:0] SEL_DEV = 2'd0;
    localparam logic [1:0] SEL_MEM = 2'd1;
    localparam logic [1:0] SEL_CNT = 2'd2;
    localparam logic [1:0] SEL_CMD = 2'd3;

    localparam int CMD_DIR_BIT   = 0;
    localparam int CMD_START_BIT = 1;
    localparam int CMD_CLR_BIT   = 2;

endpackage

// File: rtl/cs_dma_regs.sv
module cs_dma_regs
    import cs_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_wr,
    input  logic [1:0]    prog_sel,
    input  logic [DW-1:0] prog_wdata,
    input  logic          busy_i,
    input  logic          fin_i,
    output logic [AW-1:0] dev_o,
    output logic [AW-1:0] mem_o,
    output logic [CW-1:0] cnt_o,
    output logic          dir_o,
    output logic          launch_o,
    output logic          done_o
);

    typedef struct packed {
        logic [AW-1:0] dev;
        logic [AW-1:0] mem;
        logic [CW-1:0] cnt;
        logic          dir;
        logic          done;
    } regs_t;

    regs_t r_d, r_q;
    logic  take;
    logic  is_cmd;

    always_comb begin
        r_d      = r_q;
        launch_o = 1'b0;
        take     = prog_wr && !busy_i;
        is_cmd   = (prog_sel == SEL_CMD);
        if (take) begin
            case (prog_sel)
                SEL_DEV: r_d.dev = prog_wdata[AW-1:0];
                SEL_MEM: r_d.mem = prog_wdata[AW-1:0];
                SEL_CNT: r_d.cnt = prog_wdata[CW-1:0];
                default: begin
                    r_d.dir = prog_wdata[CMD_DIR_BIT];
                    if (prog_wdata[CMD_CLR_BIT]) r_d.done = 1'b0;
                    if (prog_wdata[CMD_START_BIT]) begin
                        r_d.done = (r_q.cnt == '0);
                        launch_o = (r_q.cnt != '0);
                    end
                end
            endcase
        end
        if (fin_i) r_d.done = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign dev_o  = r_q.dev;
    assign mem_o  = r_q.mem;
    assign cnt_o  = r_q.cnt;
    assign dir_o  = r_d.dir;
    assign done_o = r_q.done;

    // R9: settings frozen while a block runs
    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> ($stable(dev_o) && $stable(mem_o) && $stable(cnt_o)));

    // R8: zero-length start completes at once without busy
    a_r8_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_wr && is_cmd && prog_wdata[CMD_START_BIT] && !busy_i && cnt_o == '0)
        |=> (done_o && !busy_i));

    // R7: done flag holds until clear or start accepted
    a_r7_done_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !(prog_wr && !busy_i && is_cmd &&
                     (prog_wdata[CMD_CLR_BIT] || prog_wdata[CMD_START_BIT])))
        |=> done_o);

endmodule

// File: rtl/cs_dma_seq.sv
module cs_dma_seq
    import cs_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic          dir_i,
    input  logic [AW-1:0] dev_i,
    input  logic [AW-1:0] mem_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          bus_grant,
    input  logic [DW-1:0] bus_rdata,
    output logic          bus_req,
    output logic          bus_valid,
    output logic          bus_we,
    output logic          bus_io,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    output logic          busy_o,
    output logic          fin_o
);

    localparam logic [CW-1:0] LAST_ONE = CW'(1);

    typedef struct packed {
        seq_st_e       st;
        logic          dir;
        logic [AW-1:0] dev;
        logic [AW-1:0] mem;
        logic [CW-1:0] cnt;
        logic [DW-1:0] hold;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        fin_o     = 1'b0;
        bus_req   = 1'b0;
        bus_valid = 1'b0;
        bus_we    = 1'b0;
        bus_io    = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        case (s_q.st)
            ST_IDLE: begin
                if (launch_i) begin
                    s_d.st  = ST_SRC;
                    s_d.dir = dir_i;
                    s_d.dev = dev_i;
                    s_d.mem = mem_i;
                    s_d.cnt = cnt_i;
                end
            end
            ST_SRC: begin
                bus_req = 1'b1;
                if (bus_grant) begin
                    bus_valid = 1'b1;
                    bus_io    = !s_q.dir;
                    bus_addr  = s_q.dir ? s_q.mem : s_q.dev;
                    s_d.hold  = bus_rdata;
                    s_d.st    = ST_HOLD;
                end
            end
            ST_HOLD: s_d.st = ST_DST;
            ST_DST: begin
                bus_req = 1'b1;
                if (bus_grant) begin
                    bus_valid = 1'b1;
                    bus_we    = 1'b1;
                    bus_io    = s_q.dir;
                    bus_addr  = s_q.dir ? s_q.dev : s_q.mem;
                    bus_wdata = s_q.hold;
                    s_d.mem   = s_q.mem + AW'(1);
                    s_d.cnt   = s_q.cnt - CW'(1);
                    if (s_q.cnt == LAST_ONE) begin
                        s_d.st = ST_IDLE;
                        fin_o  = 1'b1;
                    end else begin
                        s_d.st = ST_REST;
                    end
                end
            end
            ST_REST: s_d.st = ST_SRC;
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.st != ST_IDLE);

    // R4: bus released in the cycle after each transaction
    a_r4_release: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |=> !bus_req);

    // R5: memory address steps by one per retired word
    a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DST && bus_grant) |=> (s_q.mem == $past(s_q.mem) + AW'(1)));

    // R5: word count steps down by one per retired word
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_DST && bus_grant) |=> (s_q.cnt == $past(s_q.cnt) - CW'(1)));

    // R6: finishing leaves the engine idle
    a_r6_fin_idle: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |=> !busy_o);

endmodule

// File: rtl/cs_dma_top.sv
module cs_dma_top
    import cs_dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int DW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_wr,
    input  logic [1:0]    prog_sel,
    input  logic [DW-1:0] prog_wdata,
    output logic          busy,
    output logic          irq,
    output logic          bus_req,
    input  logic          bus_grant,
    output logic          bus_valid,
    output logic          bus_we,
    output logic          bus_io,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata
);

    logic [AW-1:0] cfg_dev, cfg_mem;
    logic [CW-1:0] cfg_cnt;
    logic          cfg_dir, launch, fin;

    cs_dma_regs #(.AW(AW), .DW(DW), .CW(CW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .prog_wr    (prog_wr),
        .prog_sel   (prog_sel),
        .prog_wdata (prog_wdata),
        .busy_i     (busy),
        .fin_i      (fin),
        .dev_o      (cfg_dev),
        .mem_o      (cfg_mem),
        .cnt_o      (cfg_cnt),
        .dir_o      (cfg_dir),
        .launch_o   (launch),
        .done_o     (irq)
    );

    cs_dma_seq #(.AW(AW), .DW(DW), .CW(CW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch_i  (launch),
        .dir_i     (cfg_dir),
        .dev_i     (cfg_dev),
        .mem_i     (cfg_mem),
        .cnt_i     (cfg_cnt),
        .bus_grant (bus_grant),
        .bus_rdata (bus_rdata),
        .bus_req   (bus_req),
        .bus_valid (bus_valid),
        .bus_we    (bus_we),
        .bus_io    (bus_io),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .busy_o    (busy),
        .fin_o     (fin)
    );

    // R6: interrupt never coexists with a running block
    a_r6_irq_idle: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !busy);

    // R4: a transaction only happens under an active request
    a_r4_valid_req: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid |-> (bus_req && bus_grant));

endmodule

// File: tb/cs_dma_top_tb_top.sv
module cs_dma_top_tb_top;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prog_wr = 1'b0;
    logic [1:0]    prog_sel = 2'd0;
    logic [DW-1:0] prog_wdata = '0;
    logic          busy, irq, bus_req, bus_valid, bus_we, bus_io;
    logic          bus_grant;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata, bus_rdata;

    always #2.5 clk = ~clk;

    cs_dma_top #(.AW(AW), .DW(DW), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .prog_wr(prog_wr), .prog_sel(prog_sel),
        .prog_wdata(prog_wdata), .busy(busy), .irq(irq), .bus_req(bus_req),
        .bus_grant(bus_grant), .bus_valid(bus_valid), .bus_we(bus_we),
        .bus_io(bus_io), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dev_word(logic [15:0] a, int k);
        return {a[7:0] ^ 8'hA5, k[7:0]};
    endfunction

    function automatic logic [15:0] mem_init(int i);
        return 16'(i * 16'h0101) ^ 16'h3C00;
    endfunction

    // ---------------- behavioural bus: memory, peripheral, arbiter ----------------
    logic [15:0] mem [256];
    logic [15:0] dev_sink [$];
    int          dev_rd_k = 0;
    logic        allow = 1'b1;
    logic        rand_grant = 1'b0;
    logic [7:0]  lfsr = 8'hB7;

    assign bus_grant = bus_req && allow;

    always_comb begin
        if (bus_valid && !bus_we)
            bus_rdata = bus_io ? dev_word(bus_addr, dev_rd_k) : mem[bus_addr[7:0]];
        else
            bus_rdata = 16'hDEAD;
    end

    always @(posedge clk) begin
        if (bus_valid && bus_we && !bus_io) mem[bus_addr[7:0]] <= bus_wdata;
        if (bus_valid && bus_we && bus_io)  dev_sink.push_back(bus_wdata);
        if (bus_valid && !bus_we && bus_io) dev_rd_k <= dev_rd_k + 1;
    end

    always begin
        @(posedge clk);
        #1;
        lfsr  = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        allow = rand_grant ? lfsr[0] : 1'b1;
    end

    // ---------------- reference model, evaluated every cycle ----------------
    typedef struct {
        logic [15:0] addr;
        logic        io;
        logic        we;
        logic [15:0] data;
        logic        has_data;
    } txn_t;

    txn_t        exp_q [$];
    logic [15:0] ref_mem [256];
    logic [15:0] ref_sink [$];
    logic [15:0] m_dev = '0, m_mem = '0;
    logic [7:0]  m_cnt = '0;
    logic        m_dir = 1'b0, m_busy = 1'b0, m_done = 1'b0;
    int          m_devk = 0;
    logic        prev_valid = 1'b0;

    task automatic model_launch();
        for (int i = 0; i < int'(m_cnt); i++) begin
            txn_t a, b;
            logic [15:0] w;
            logic [15:0] ma;
            ma = m_mem + 16'(i);
            if (!m_dir) begin
                w = dev_word(m_dev, m_devk + i);
                a = '{addr: m_dev, io: 1'b1, we: 1'b0, data: 16'h0, has_data: 1'b0};
                b = '{addr: ma, io: 1'b0, we: 1'b1, data: w, has_data: 1'b1};
                ref_mem[ma[7:0]] = w;
            end else begin
                w = ref_mem[ma[7:0]];
                a = '{addr: ma, io: 1'b0, we: 1'b0, data: 16'h0, has_data: 1'b0};
                b = '{addr: m_dev, io: 1'b1, we: 1'b1, data: w, has_data: 1'b1};
                ref_sink.push_back(w);
            end
            exp_q.push_back(a);
            exp_q.push_back(b);
        end
        if (!m_dir) m_devk = m_devk + int'(m_cnt);
    endtask

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_valid = 1'b0;
        end else begin
            // compare state registered on the last edge
            chk("R10 busy", 32'(busy), 32'(m_busy));
            chk("R7 irq", 32'(irq), 32'(m_done));
            if (prev_valid) chk("R4 request after transaction", 32'(bus_req), 32'd0);
            if (!m_busy)    chk("R4 request while idle", 32'(bus_req), 32'd0);
            // events of this cycle, retired on the next edge
            if (prog_wr && !m_busy) begin
                case (prog_sel)
                    2'd0: m_dev = prog_wdata;
                    2'd1: m_mem = prog_wdata;
                    2'd2: m_cnt = prog_wdata[7:0];
                    default: begin
                        m_dir = prog_wdata[0];
                        if (prog_wdata[2]) m_done = 1'b0;
                        if (prog_wdata[1]) begin
                            if (m_cnt == 8'd0) m_done = 1'b1;
                            else begin
                                m_done = 1'b0;
                                m_busy = 1'b1;
                                model_launch();
                            end
                        end
                    end
                endcase
            end
            if (bus_valid) begin
                if (exp_q.size() == 0) begin
                    chk("R4 unexpected transaction", 32'd1, 32'd0);
                end else begin
                    txn_t e;
                    e = exp_q.pop_front();
                    chk("R5 address", 32'(bus_addr), 32'(e.addr));
                    chk("R3 target", 32'(bus_io), 32'(e.io));
                    chk("R3 write flag", 32'(bus_we), 32'(e.we));
                    if (e.has_data) chk("R3 carried word", 32'(bus_wdata), 32'(e.data));
                    if (exp_q.size() == 0) begin
                        m_busy = 1'b0;
                        m_done = 1'b1;
                    end
                end
            end
            prev_valid = bus_valid;
        end
    end

    // ---------------- watchdog ----------------
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    task automatic wr(logic [1:0] sel, logic [15:0] d);
        prog_wr = 1'b1;
        prog_sel = sel;
        prog_wdata = d;
        @(posedge clk); #1;
        prog_wr = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic wait_done();
        for (int i = 0; i < 2000 && !(irq && !busy); i++) begin @(posedge clk); #1; end
    endtask

    task automatic check_images(string tag);
        int diffs;
        diffs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== ref_mem[i]) diffs++;
        chk({tag, " memory image"}, 32'(diffs), 32'd0);
        chk({tag, " peripheral words"}, 32'(dev_sink.size()), 32'(ref_sink.size()));
        diffs = 0;
        for (int i = 0; i < dev_sink.size() && i < ref_sink.size(); i++)
            if (dev_sink[i] !== ref_sink[i]) diffs++;
        chk({tag, " peripheral data"}, 32'(diffs), 32'd0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = mem_init(i);
            ref_mem[i] = mem_init(i);
        end
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 busy", 32'(busy), 32'd0);
        chk("R1 irq", 32'(irq), 32'd0);
        chk("R1 bus_req", 32'(bus_req), 32'd0);
        chk("R1 bus_valid", 32'(bus_valid), 32'd0);
        rst_n = 1'b1;
        idle(2);

        // R2/R3: peripheral to memory, grant always available
        wr(2'd0, 16'h0011);
        wr(2'd1, 16'h0010);
        wr(2'd2, 16'd5);
        wr(2'd3, 16'h0002);
        wait_done();
        chk("R6 irq at end of block", 32'(irq), 32'd1);
        idle(5);
        chk("R7 irq held", 32'(irq), 32'd1);
        wr(2'd3, 16'h0004);
        idle(1);
        chk("R7 irq cleared", 32'(irq), 32'd0);
        check_images("R2");

        // memory to peripheral under irregular grants
        rand_grant = 1'b1;
        wr(2'd0, 16'h0022);
        wr(2'd1, 16'h0040);
        wr(2'd2, 16'd6);
        wr(2'd3, 16'h0003);
        wait_done();
        wr(2'd3, 16'h0004);
        check_images("R3");

        // R8: zero-length block
        wr(2'd2, 16'd0);
        wr(2'd3, 16'h0002);
        chk("R8 irq", 32'(irq), 32'd1);
        chk("R8 busy", 32'(busy), 32'd0);
        idle(3);
        chk("R8 no bus traffic", 32'(bus_req), 32'd0);
        wr(2'd3, 16'h0004);

        // R9: writes during a block, then a start held through completion
        wr(2'd0, 16'h0033);
        wr(2'd1, 16'h0080);
        wr(2'd2, 16'd4);
        wr(2'd3, 16'h0002);
        wr(2'd0, 16'hFFFF);
        wr(2'd1, 16'h00F0);
        wr(2'd2, 16'h0055);
        wr(2'd3, 16'h0005);
        prog_wr = 1'b1;
        prog_sel = 2'd3;
        prog_wdata = 16'h0002;
        for (int i = 0; i < 2000 && busy; i++) begin @(posedge clk); #1; end
        @(posedge clk); #1;
        prog_wr = 1'b0;
        chk("R10 relaunch busy", 32'(busy), 32'd1);
        wait_done();
        wr(2'd3, 16'h0004);
        check_images("R9");

        // single word, start and clear in one command
        wr(2'd0, 16'h0044);
        wr(2'd1, 16'h00C0);
        wr(2'd2, 16'd1);
        wr(2'd3, 16'h0007);
        wait_done();
        chk("R6 single word done", 32'(irq), 32'd1);
        wr(2'd3, 16'h0004);
        idle(2);
        check_images("R5");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule